// File: doc/BRIEF.md
# Dual-Channel Sample Formatter and Lane Serializer

This block takes one pair of 20-bit two's-complement conversion results per sample, one for each of two channels, and sends them out as serial bit streams on one or two output lanes. Each result is first recoded to the selected number coding. It is then placed in a 20-bit or 24-bit word and can optionally be scrambled. The words are shifted out most significant bit first, either one bit per clock cycle or two bits per cycle for a double-data-rate output cell. A strobe marks the first cycle of every frame.

A sample is captured when `smp_valid` is high. The sample waits in a one-entry holding register until the serializer is idle, or until the serializer is in the last cycle of the current frame. When the frame starts, the configuration inputs are captured together with the sample. Frames can therefore run back to back, and a configuration change made during a frame does not disturb that frame.

Top module: `adc_lane_serializer`

## Requirements
- R1: The lane code `cfg_lanes` is decoded by bit position. Bit 2 set means single-lane output and bit 1 set means 24-bit words. This gives 0 for two lanes at 20 bits, 2 for two lanes at 24 bits, 5 for one lane at 20 bits and 7 for one lane at 24 bits. In two-lane modes channel A is sent on lane A and channel B on lane B.
- R2: When `cfg_twos` is 1 the result is sent unchanged as two's complement. When it is 0 the result is sent as straight binary, which is the two's-complement value with its MSB inverted.
- R3: In 24-bit modes the 20-bit result fills the upper 20 bits of the word and the 4 least significant bits are zero. This padding is done before any scrambling.
- R4: With `cfg_xor_en` at 0 the word bits are sent unmodified and no extra bit is added.
- R5: With `cfg_xor_en` at 1 and `cfg_xor_sel` at 0, every word bit is XORed with the sample's PRBS bit. The PRBS bit itself follows the word's LSB, so each channel slot is one bit longer than the word.
- R6: With `cfg_xor_en` at 1 and `cfg_xor_sel` at 1, every word bit is XORed with bit 0 of that channel's unrecoded result, and no extra bit is sent.
- R7: The scrambler is a 7-bit LFSR for x^7 + x^6 + 1, set to all ones at reset. The PRBS bit of a frame is state[6] XOR state[5]. The state advances as {state[5:0], bit} once at each frame start, and both channels of one sample use the same bit.
- R8: In single-lane modes, channel A's slot and then channel B's slot are sent on lane A with no gap between them, and lane B stays 0 for the whole frame.
- R9: With `cfg_sdr` at 1, one bit is sent per cycle, and both bits of a lane output carry that same bit. With `cfg_sdr` at 0, two bits are sent per cycle: bit 1 carries the earlier bit and bit 0 the later one. A frame with an odd number of bits ends with a 0 in its last later half.
- R10: `frame_strobe` is high only in the first cycle of each frame. When no frame is running, both lane outputs are 0.
- R11: The data and configuration are captured when a frame starts. Changes to the configuration inputs during a frame do not affect that frame.
- R12: A sample that arrives during a frame starts its own frame in the cycle right after the current frame's last cycle. If two samples arrive before a frame can start, only the later one is sent.
- R13: While and just after reset, the strobe and both lane outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | Sample present on `smp_a`/`smp_b` this cycle |
| smp_a | input | 20 | Channel A result, two's complement |
| smp_b | input | 20 | Channel B result, two's complement |
| cfg_lanes | input | 3 | Lane code (R1) |
| cfg_twos | input | 1 | 1 selects two's complement, 0 selects straight binary |
| cfg_xor_en | input | 1 | Scrambling enable |
| cfg_xor_sel | input | 1 | 0 selects the PRBS bit, 1 selects the result LSB |
| cfg_sdr | input | 1 | 1 selects single data rate, 0 selects double data rate |
| lane_a_q | output | 2 | Lane A bits for this cycle, earlier bit in bit 1 |
| lane_b_q | output | 2 | Lane B bits for this cycle, earlier bit in bit 1 |
| frame_strobe | output | 1 | First cycle of a frame |

## Verification
The bench drives every lane code at both data rates and compares each lane's whole bit stream with a model built from the requirements. One target is the DDR frame with an odd bit count, which comes from the 21-bit slot with the appended PRBS bit. A shifter that does not drain cleanly would leave a stray bit in the final half-cycle or run one cycle short. Samples whose LSB differs are used to separate the two scrambling sources. The run is long enough for the PRBS bit to turn to 1, so a bench that only ever saw zeros would not hide a wrong tap or a wrong advance. Other targets are a configuration change in the middle of a frame, which a design reading the live inputs would apply to bits already in flight, and two samples arriving inside one frame, where a design that keeps the older sample or inserts an idle cycle would be caught.

// File: rtl/adc_ser_pkg.sv
package adc_ser_pkg;
  // Width of one conversion result and zero padding added in wide modes
  parameter int SMP_W = 20;
  parameter int PAD_W = 4;
  parameter int NUM_LANES = 2;
endpackage

// File: rtl/prbs7_gen.sv
module prbs7_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic adv,
  output logic bit_o
);
  localparam int ORD = 7;

  logic [ORD-1:0] st_q, st_d;

  assign bit_o = st_q[ORD-1] ^ st_q[ORD-2];

  always_comb begin
    st_d = st_q;
    if (adv) st_d = {st_q[ORD-2:0], bit_o};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= '1;
    else if (adv) st_q <= st_d;
  end

  // R7
  prbs_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_q != '0);
endmodule

// File: rtl/ch_formatter.sv
module ch_formatter #(
  parameter int DW = 20,
  parameter int PAD = 4,
  localparam int SLOT = DW + PAD + 1,
  localparam int LW = $clog2(SLOT + 1)
) (
  input  logic [DW-1:0]   result,
  input  logic            twos,
  input  logic            wide,
  input  logic            xor_en,
  input  logic            xor_sel,
  input  logic            prbs_bit,
  output logic [SLOT-1:0] slot,
  output logic [LW-1:0]   slot_len
);
  logic [DW-1:0]   coded;
  logic [SLOT-1:0] base, mask, tail;
  logic [LW-1:0]   wbits;
  logic            flip, add;

  always_comb begin
    coded = twos ? result : {~result[DW-1], result[DW-2:0]};
    base  = {coded, {(PAD+1){1'b0}}};
    wbits = wide ? LW'(DW + PAD) : LW'(DW);
    mask  = ~({SLOT{1'b1}} >> wbits);
    tail  = {1'b1, {(SLOT-1){1'b0}}} >> wbits;
    flip  = xor_sel ? result[0] : prbs_bit;
    add   = xor_en & ~xor_sel;
    slot  = (base ^ ({SLOT{xor_en & flip}} & mask)) | ({SLOT{add & prbs_bit}} & tail);
    slot_len = wbits + LW'(add);
  end
endmodule

// File: rtl/lane_shifter.sv
module lane_shifter #(
  parameter int SW = 50
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          load,
  input  logic [SW-1:0] vec,
  input  logic          ddr,
  output logic [1:0]    q
);
  logic [SW-1:0] sr_q, sr_d;

  always_comb begin
    if (load)     sr_d = vec;
    else if (ddr) sr_d = sr_q << 2;
    else          sr_d = sr_q << 1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  sr_q <= '0;
    else if (en) sr_q <= sr_d;
  end

  assign q = {sr_q[SW-1], ddr ? sr_q[SW-2] : sr_q[SW-1]};
endmodule

// File: rtl/adc_lane_serializer.sv
module adc_lane_serializer
  import adc_ser_pkg::*;
#(
  parameter int DW = SMP_W,
  parameter int PAD = PAD_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          smp_valid,
  input  logic [DW-1:0] smp_a,
  input  logic [DW-1:0] smp_b,
  input  logic [2:0]    cfg_lanes,
  input  logic          cfg_twos,
  input  logic          cfg_xor_en,
  input  logic          cfg_xor_sel,
  input  logic          cfg_sdr,
  output logic [1:0]    lane_a_q,
  output logic [1:0]    lane_b_q,
  output logic          frame_strobe
);
  localparam int SLOT   = DW + PAD + 1;
  localparam int LW     = $clog2(SLOT + 1);
  localparam int STREAM = 2 * SLOT;
  localparam int CW     = $clog2(STREAM + 1);

  // Holding register for one sample
  logic          pend_q, pend_d;
  logic [DW-1:0] pa_q, pb_q, pa_d, pb_d;
  // Frame control
  logic          busy_q, busy_d, ddr_q, ddr_d, single_q, single_d, strobe_d;
  logic [CW-1:0] cnt_q, cnt_d, frame_bits, cycles;
  logic          start, last, prbs_bit;

  logic [DW-1:0]     res   [NUM_LANES];
  logic [SLOT-1:0]   slot  [NUM_LANES];
  logic [LW-1:0]     slen  [NUM_LANES];
  logic [STREAM-1:0] vec   [NUM_LANES];
  logic [1:0]        lane_q[NUM_LANES];

  assign last  = busy_q & (cnt_q == '0);
  assign start = pend_q & (~busy_q | last);
  assign res[0] = pa_q;
  assign res[1] = pb_q;

  prbs7_gen u_prbs (.clk(clk), .rst_n(rst_n), .adv(start), .bit_o(prbs_bit));

  for (genvar ch = 0; ch < NUM_LANES; ch++) begin : g_fmt
    ch_formatter #(.DW(DW), .PAD(PAD)) u_fmt (
      .result(res[ch]), .twos(cfg_twos), .wide(cfg_lanes[1]),
      .xor_en(cfg_xor_en), .xor_sel(cfg_xor_sel), .prbs_bit(prbs_bit),
      .slot(slot[ch]), .slot_len(slen[ch]));
  end

  // Lane stream assembly and frame length
  always_comb begin
    frame_bits = CW'(slen[0]) << cfg_lanes[2];
    cycles     = cfg_sdr ? frame_bits : CW'((frame_bits + 1'b1) >> 1);
    vec[0]     = {slot[0], {SLOT{1'b0}}};
    vec[1]     = {slot[1], {SLOT{1'b0}}};
    if (cfg_lanes[2]) begin
      vec[0] = vec[0] | ({slot[1], {SLOT{1'b0}}} >> slen[0]);
      vec[1] = '0;
    end
  end

  // Next-state logic
  always_comb begin
    pend_d   = pend_q;
    pa_d     = pa_q;
    pb_d     = pb_q;
    busy_d   = busy_q;
    cnt_d    = cnt_q;
    ddr_d    = ddr_q;
    single_d = single_q;
    strobe_d = start;
    if (start) pend_d = 1'b0;
    if (smp_valid) begin
      pend_d = 1'b1;
      pa_d   = smp_a;
      pb_d   = smp_b;
    end
    if (start) begin
      busy_d   = 1'b1;
      cnt_d    = cycles - 1'b1;
      ddr_d    = ~cfg_sdr;
      single_d = cfg_lanes[2];
    end else if (last) begin
      busy_d = 1'b0;
    end else if (busy_q) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q       <= 1'b0;
      pa_q         <= '0;
      pb_q         <= '0;
      busy_q       <= 1'b0;
      cnt_q        <= '0;
      ddr_q        <= 1'b0;
      single_q     <= 1'b0;
      frame_strobe <= 1'b0;
    end else begin
      pend_q       <= pend_d;
      frame_strobe <= strobe_d;
      if (smp_valid) begin
        pa_q <= pa_d;
        pb_q <= pb_d;
      end
      if (start | busy_q) begin
        busy_q   <= busy_d;
        cnt_q    <= cnt_d;
        ddr_q    <= ddr_d;
        single_q <= single_d;
      end
    end
  end

  for (genvar ln = 0; ln < NUM_LANES; ln++) begin : g_lane
    lane_shifter #(.SW(STREAM)) u_sh (
      .clk(clk), .rst_n(rst_n), .en(start | busy_q), .load(start),
      .vec(vec[ln]), .ddr(ddr_q), .q(lane_q[ln]));
  end

  assign lane_a_q = lane_q[0];
  assign lane_b_q = lane_q[1];

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> (lane_a_q == 2'b00 && lane_b_q == 2'b00));
  // R10
  strobe_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_strobe |=> !frame_strobe);
  // R8
  single_lane_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && single_q) |-> lane_b_q == 2'b00);
  // R9
  sdr_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !ddr_q) |-> (lane_a_q[1] == lane_a_q[0] && lane_b_q[1] == lane_b_q[0]));
  // R12
  back_to_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && busy_q && cnt_q == '0) |=> frame_strobe);
endmodule

// File: tb/adc_lane_serializer_tb.sv
module adc_lane_serializer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        smp_valid = 1'b0;
  logic [19:0] smp_a = '0, smp_b = '0;
  logic [2:0]  cfg_lanes = 3'd2;
  logic        cfg_twos = 1'b1, cfg_xor_en = 1'b0, cfg_xor_sel = 1'b0, cfg_sdr = 1'b0;
  logic [1:0]  lane_a_q, lane_b_q;
  logic        frame_strobe;

  int errors = 0;
  int checks = 0;
  int pushed = 0;
  int frames_seen = 0;
  logic [6:0] prbs_st = 7'h7F;

  typedef struct {
    logic [63:0] va;
    logic [63:0] vb;
    int          cyc;
    bit          ddr;
    string       tag;
  } exp_t;
  exp_t expq[$];

  always #4 clk = ~clk;

  adc_lane_serializer u_dut (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_a(smp_a), .smp_b(smp_b),
    .cfg_lanes(cfg_lanes), .cfg_twos(cfg_twos), .cfg_xor_en(cfg_xor_en),
    .cfg_xor_sel(cfg_xor_sel), .cfg_sdr(cfg_sdr),
    .lane_a_q(lane_a_q), .lane_b_q(lane_b_q), .frame_strobe(frame_strobe));

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, expv);
    end
  endtask

  // Appends one channel slot to a left-justified bit vector
  task automatic add_slot(inout logic [63:0] v, inout int pos, input logic [19:0] r, input logic p);
    logic [19:0] coded;
    logic [23:0] val;
    int          w;
    logic        x;
    coded = cfg_twos ? r : (r ^ 20'h80000);
    w     = cfg_lanes[1] ? 24 : 20;
    val   = cfg_lanes[1] ? {coded, 4'h0} : {4'h0, coded};
    x     = cfg_xor_en ? (cfg_xor_sel ? r[0] : p) : 1'b0;
    for (int i = w - 1; i >= 0; i--) begin
      v[63-pos] = val[i] ^ x;
      pos++;
    end
    if (cfg_xor_en && !cfg_xor_sel) begin
      v[63-pos] = p;
      pos++;
    end
  endtask

  task automatic push_exp(input logic [19:0] a, input logic [19:0] b, input string tag);
    exp_t e;
    int   pa, pb;
    logic p;
    p = prbs_st[6] ^ prbs_st[5];
    prbs_st = {prbs_st[5:0], p};
    e.va = '0; e.vb = '0; pa = 0; pb = 0;
    add_slot(e.va, pa, a, p);
    if (cfg_lanes[2]) add_slot(e.va, pa, b, p);
    else              add_slot(e.vb, pb, b, p);
    e.ddr = !cfg_sdr;
    e.cyc = cfg_sdr ? pa : (pa + 1) / 2;
    e.tag = tag;
    expq.push_back(e);
    pushed++;
  endtask

  task automatic pulse(input logic [19:0] a, input logic [19:0] b);
    @(negedge clk);
    smp_valid = 1'b1; smp_a = a; smp_b = b;
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  task automatic wait_done();
    while (frames_seen < pushed) @(negedge clk);
  endtask

  task automatic send(input logic [19:0] a, input logic [19:0] b, input string tag);
    push_exp(a, b, tag);
    pulse(a, b);
    wait_done();
  endtask

  task automatic set_cfg(input logic [2:0] ln, input logic tc, input logic xe, input logic xs, input logic sdr);
    @(negedge clk);
    cfg_lanes = ln; cfg_twos = tc; cfg_xor_en = xe; cfg_xor_sel = xs; cfg_sdr = sdr;
  endtask

  // Monitor: pops the expected frame at each strobe and compares both lanes
  initial begin
    exp_t        e;
    logic [63:0] ra, rb;
    int          pos;
    bit          shape_ok;
    forever begin
      @(negedge clk);
      if (rst_n && frame_strobe) begin
        if (expq.size() == 0) begin
          check(1'b0, "R10 unexpected frame", 64'd1, 64'd0);
        end else begin
          e = expq.pop_front();
          ra = '0; rb = '0; pos = 0; shape_ok = 1'b1;
          for (int c = 0; c < e.cyc; c++) begin
            if (c > 0) begin
              @(negedge clk);
              if (frame_strobe) shape_ok = 1'b0;
            end
            ra[63-pos] = lane_a_q[1];
            rb[63-pos] = lane_b_q[1];
            if (!e.ddr && (lane_a_q[0] != lane_a_q[1] || lane_b_q[0] != lane_b_q[1])) shape_ok = 1'b0;
            pos++;
            if (e.ddr) begin
              ra[63-pos] = lane_a_q[0];
              rb[63-pos] = lane_b_q[0];
              pos++;
            end
          end
          check(ra == e.va, {e.tag, " lane A"}, ra, e.va);
          check(rb == e.vb, {e.tag, " lane B"}, rb, e.vb);
          check(shape_ok, {e.tag, " R9 R10 frame shape"}, 64'(shape_ok), 64'd1);
          frames_seen++;
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R13 outputs quiet in reset
    check(frame_strobe == 1'b0 && lane_a_q == 2'b00 && lane_b_q == 2'b00, "R13 in reset",
          {lane_a_q, lane_b_q, frame_strobe}, 64'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(frame_strobe == 1'b0 && lane_a_q == 2'b00 && lane_b_q == 2'b00, "R13 after reset",
          {lane_a_q, lane_b_q, frame_strobe}, 64'd0);

    // R1 two lanes 24-bit, DDR, two's complement (R2, R3)
    set_cfg(3'd2, 1'b1, 1'b0, 1'b0, 1'b0);
    send(20'h12345, 20'hABCDE, "R1 R3 mode2 ddr");
    send(20'h7FFFF, 20'h80000, "R2 R3 mode2 extremes");
    // R1 two lanes 20-bit, SDR
    set_cfg(3'd0, 1'b1, 1'b0, 1'b0, 1'b1);
    send(20'h0F0F1, 20'hFFFFF, "R1 R9 mode0 sdr");
    // R1 R8 single lane modes at both rates
    set_cfg(3'd5, 1'b1, 1'b0, 1'b0, 1'b0);
    send(20'h55555, 20'hAAAAA, "R1 R8 mode5 ddr");
    set_cfg(3'd7, 1'b1, 1'b0, 1'b0, 1'b1);
    send(20'h13579, 20'h2468A, "R1 R8 mode7 sdr");
    set_cfg(3'd7, 1'b1, 1'b0, 1'b0, 1'b0);
    send(20'hC3A5F, 20'h00001, "R3 R8 mode7 ddr");
    set_cfg(3'd5, 1'b1, 1'b0, 1'b0, 1'b1);
    send(20'h80001, 20'h7FFFE, "R8 mode5 sdr");
    // R2 straight binary
    set_cfg(3'd0, 1'b0, 1'b0, 1'b0, 1'b0);
    send(20'h80000, 20'h7FFFF, "R2 offset extremes");
    send(20'h00000, 20'hFFFFF, "R2 offset midscale");
    // R4 no scrambling with other data
    set_cfg(3'd2, 1'b1, 1'b0, 1'b0, 1'b1);
    send(20'hFFFFF, 20'h00001, "R4 plain");
    // R6 LSB fold, odd and even LSB
    set_cfg(3'd0, 1'b1, 1'b1, 1'b1, 1'b1);
    send(20'h12341, 20'h12340, "R6 lsb fold mode0");
    set_cfg(3'd7, 1'b0, 1'b1, 1'b1, 1'b0);
    send(20'hABCDF, 20'h65432, "R6 R3 lsb fold mode7");
    // R5 R7 PRBS bit appended, odd DDR frame, run long enough for a 1 bit
    set_cfg(3'd0, 1'b1, 1'b1, 1'b0, 1'b0);
    for (int k = 0; k < 10; k++)
      send(20'h3C3C3 + 20'(k * 97), 20'hC3C3C - 20'(k * 31), "R5 R7 prbs mode0 ddr");
    set_cfg(3'd7, 1'b1, 1'b1, 1'b0, 1'b1);
    send(20'h11111, 20'h22222, "R5 R8 prbs mode7 sdr");
    set_cfg(3'd5, 1'b1, 1'b1, 1'b0, 1'b0);
    send(20'h9ABCD, 20'h0000F, "R5 R9 prbs mode5 ddr");

    // R11 configuration change during a frame
    set_cfg(3'd2, 1'b1, 1'b0, 1'b0, 1'b1);
    push_exp(20'h5A5A5, 20'hA5A5A, "R11 mid-frame cfg");
    pulse(20'h5A5A5, 20'hA5A5A);
    while (!frame_strobe) @(negedge clk);
    cfg_lanes = 3'd5; cfg_twos = 1'b0; cfg_xor_en = 1'b1; cfg_sdr = 1'b0;
    repeat (4) @(negedge clk);
    cfg_lanes = 3'd2; cfg_twos = 1'b1; cfg_xor_en = 1'b0; cfg_sdr = 1'b1;
    wait_done();

    // R12 two samples during one frame, latest wins, back to back
    set_cfg(3'd0, 1'b1, 1'b0, 1'b0, 1'b1);
    push_exp(20'h11223, 20'h44556, "R12 first");
    pulse(20'h11223, 20'h44556);
    while (!frame_strobe) @(negedge clk);
    smp_valid = 1'b1; smp_a = 20'hDEAD0; smp_b = 20'hBEEF0;
    @(negedge clk);
    smp_a = 20'h0BEEF; smp_b = 20'h0CAFE;
    @(negedge clk);
    smp_valid = 1'b0;
    push_exp(20'h0BEEF, 20'h0CAFE, "R12 latest");
    wait_done();

    // R10 idle outputs quiet
    repeat (3) @(negedge clk);
    check(frame_strobe == 1'b0 && lane_a_q == 2'b00 && lane_b_q == 2'b00, "R10 idle",
          {lane_a_q, lane_b_q, frame_strobe}, 64'd0);
    check(expq.size() == 0, "R12 no extra frames pending", 64'(expq.size()), 64'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule